// File: doc/BRIEF.md
# Receive Word Buffer with DMA Block Transfer

This block sits between the protocol engine of a serial-bus remote terminal and a local memory. The protocol engine hands it received data words one at a time with a strobe. At the end of each message it also gives one strobe that says whether the message was good or bad. The block stores the words in a small on-chip queue. It then writes them to memory over a request/grant/acknowledge handshake, together with an output-enable strobe, a write strobe and an incrementing word address.

The mode input selects the release policy. In block mode, nothing from a message is released until the message is reported good. The whole message then goes out under a single bus request, as back-to-back three-cycle slots. A message reported bad, or one that overran the queue, is dropped without a request. In word mode, each word is released as soon as it arrives and gets its own request and its own three-cycle slot.

If the grant does not arrive within a parameterised number of cycles, the block pulses a fail flag, withdraws the request and discards the words that were waiting to go out.

Top module: `rxdma_buffer`

## Requirements
- R1: The queue stores at most DEPTH words (default 32). A message of exactly DEPTH words is delivered in full. In block mode, a word that arrives while the queue is full is not stored, and the whole message is then discarded at its completion strobe with no request.
- R2: In block mode `dma_req` stays low while a message's words arrive. It rises two cycles after the cycle in which `msg_done` is high, provided that message holds at least one word. An empty message raises no request.
- R3: In block mode one message produces exactly one rising edge of `dma_req`. The request stays high until the last word's slot ends, and each slot begins in the cycle right after the previous one ends.
- R4: In word mode every stored word produces its own rising edge of `dma_req`, and the request is low for at least one cycle between two words.
- R5: Each transfer slot is three cycles. `dma_ack` and `mem_oe` are high in all three cycles and `mem_wr` is high only in the middle one. The first slot starts the cycle after the first cycle in which `dma_grant` is seen high with the request pending. `sys_data` carries the word during the slot and is zero outside slots.
- R6: Words reach memory in arrival order. `mem_addr` starts at zero after reset, advances by one after each written word, and wraps modulo 2^ADDR_W.
- R7: In block mode, `msg_err` removes every word of the current message from the queue and no request follows. Words of an earlier, already completed message are still delivered.
- R8: If `dma_grant` is not high in any of the first GRANT_WAIT cycles of a request, `hs_fail` is high for exactly one cycle and `dma_req` is low in that cycle. The words released for that transfer are discarded, and `mem_addr` does not advance.
- R9: During and right after reset, `dma_req`, `dma_ack`, `mem_oe`, `mem_wr`, `hs_fail`, `mem_addr` and `sys_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 1 = block mode, 0 = word mode; held stable within a message |
| word_stb | input | 1 | One validated data word is present on `word_data` |
| word_data | input | DATA_W | Received data word |
| msg_done | input | 1 | Message completed without error (never together with `word_stb`) |
| msg_err | input | 1 | Message failed validation (never together with `word_stb`) |
| dma_req | output | 1 | Local bus request |
| dma_grant | input | 1 | Local bus grant |
| dma_ack | output | 1 | Bus acknowledge, high for the full transfer slot |
| mem_oe | output | 1 | Drive enable for the memory data bus |
| mem_wr | output | 1 | Memory write strobe, middle cycle of a slot |
| mem_addr | output | ADDR_W | Word address of the current write |
| sys_data | output | DATA_W | Data toward memory |
| hs_fail | output | 1 | One-cycle pulse on grant timeout |

## Verification
The hardest situation to reach from the ports is an error on a message that arrives while an earlier, completed message is still waiting for its grant or is still being written out. A correct design has to drop only the uncommitted tail of the queue in that case. The stimulus reaches it by delaying the grant for several cycles after a two-word message completes. It then streams a second message into the queue while the first is still pending and ends that second message with the error strobe. A grant that never comes, followed by a normal message, shows that the abandoned words leave no trace in the data or the address sequence.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

   // Transfer sequencer states: one request phase, then three slot cycles.
   typedef enum logic [2:0] {
      XF_IDLE  = 3'd0,
      XF_REQ   = 3'd1,
      XF_SLOT0 = 3'd2,
      XF_SLOT1 = 3'd3,
      XF_SLOT2 = 3'd4
   } xfer_state_t;

endpackage

// File: rtl/rxdma_store.sv
module rxdma_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burst_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              msg_done_i,
   input  logic              msg_err_i,
   input  logic              pop_i,
   input  logic              abandon_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [PW-1:0]     avail_o
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_bad
      $error("rxdma_store: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_width_bad
      $error("rxdma_store: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wr_ptr, commit_ptr, rd_ptr;
   logic [PW-1:0]     level;
   logic              full;
   logic              overrun;

   assign level     = wr_ptr - rd_ptr;
   assign full      = (level == PW'(DEPTH));
   assign avail_o   = commit_ptr - rd_ptr;
   assign rd_data_o = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en_i && !full && !msg_done_i && !msg_err_i) begin
         mem[wr_ptr[AW-1:0]] <= wr_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         commit_ptr <= '0;
         rd_ptr     <= '0;
         overrun    <= 1'b0;
      end else begin
         if (pop_i) begin
            rd_ptr <= rd_ptr + 1'b1;
         end else if (abandon_i) begin
            rd_ptr <= commit_ptr;
         end

         if (msg_err_i) begin
            wr_ptr  <= commit_ptr;
            overrun <= 1'b0;
         end else if (msg_done_i) begin
            if (burst_i && !overrun) begin
               commit_ptr <= wr_ptr;
            end else if (burst_i) begin
               wr_ptr <= commit_ptr;
            end
            overrun <= 1'b0;
         end else if (wr_en_i) begin
            if (full) begin
               overrun <= 1'b1;
            end else begin
               wr_ptr <= wr_ptr + 1'b1;
               if (!burst_i) begin
                  commit_ptr <= wr_ptr + 1'b1;
               end
            end
         end
      end
   end

   // R1: occupancy never exceeds the storage depth
   assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= PW'(DEPTH));

   // R7: released words are always a subset of stored words
   assert_release_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      avail_o <= level);

   // R3: a word is consumed only when one has been released
   assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (avail_o != '0));

endmodule

// File: rtl/rxdma_xfer.sv
module rxdma_xfer
   import rxdma_pkg::*;
#(
   parameter int PW         = 6,
   parameter int ADDR_W     = 12,
   parameter int GRANT_WAIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burst_i,
   input  logic [PW-1:0]     avail_i,
   input  logic              grant_i,
   output logic              req_o,
   output logic              ack_o,
   output logic              oe_o,
   output logic              wr_o,
   output logic              pop_o,
   output logic              abandon_o,
   output logic              hs_fail_o,
   output logic [ADDR_W-1:0] addr_o
);

   if (GRANT_WAIT < 1) begin : g_wait_bad
      $error("rxdma_xfer: GRANT_WAIT must be at least 1");
   end

   xfer_state_t state;
   logic        last_wait;

   if (GRANT_WAIT == 1) begin : g_no_timer
      assign last_wait = 1'b1;
   end else begin : g_timer
      localparam int CW = $clog2(GRANT_WAIT);
      logic [CW-1:0] wait_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n || state != XF_REQ) begin
            wait_cnt <= '0;
         end else if (!grant_i) begin
            wait_cnt <= wait_cnt + 1'b1;
         end
      end
      assign last_wait = (wait_cnt == CW'(GRANT_WAIT - 1));
   end

   always_comb begin
      req_o     = (state != XF_IDLE);
      ack_o     = (state == XF_SLOT0) || (state == XF_SLOT1) || (state == XF_SLOT2);
      oe_o      = ack_o;
      wr_o      = (state == XF_SLOT1);
      pop_o     = (state == XF_SLOT2);
      abandon_o = (state == XF_REQ) && !grant_i && last_wait;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= XF_IDLE;
         addr_o    <= '0;
         hs_fail_o <= 1'b0;
      end else begin
         hs_fail_o <= abandon_o;
         case (state)
            XF_IDLE:  if (avail_i != '0) state <= XF_REQ;
            XF_REQ: begin
               if (grant_i)        state <= XF_SLOT0;
               else if (last_wait) state <= XF_IDLE;
            end
            XF_SLOT0: state <= XF_SLOT1;
            XF_SLOT1: state <= XF_SLOT2;
            XF_SLOT2: begin
               addr_o <= addr_o + 1'b1;
               if (burst_i && avail_i > PW'(1)) state <= XF_SLOT0;
               else                             state <= XF_IDLE;
            end
            default:  state <= XF_IDLE;
         endcase
      end
   end

   // R5: a slot opens with the write strobe following one cycle later
   assert_wr_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |=> wr_o);

   // R5: write strobe lasts one cycle and the slot continues after it
   assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |=> (!wr_o && ack_o));

   // R3: acknowledge only under a held request
   assert_ack_under_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> req_o);

   // R8: the fail pulse coincides with a withdrawn request
   assert_fail_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hs_fail_o |-> !req_o);

   // R4: in word mode the request falls after every slot
   assert_word_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_o && !burst_i) |=> !req_o);

endmodule

// File: rtl/rxdma_buffer.sv
module rxdma_buffer #(
   parameter int DATA_W     = 16,
   parameter int DEPTH      = 32,
   parameter int ADDR_W     = 12,
   parameter int GRANT_WAIT = 16,
   localparam int PW        = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burst_mode,
   input  logic              word_stb,
   input  logic [DATA_W-1:0] word_data,
   input  logic              msg_done,
   input  logic              msg_err,
   output logic              dma_req,
   input  logic              dma_grant,
   output logic              dma_ack,
   output logic              mem_oe,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] sys_data,
   output logic              hs_fail
);

   if (ADDR_W < 1) begin : g_addr_bad
      $error("rxdma_buffer: ADDR_W must be positive");
   end

   logic [DATA_W-1:0] head_word;
   logic [PW-1:0]     avail;
   logic              pop, abandon;

   rxdma_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .burst_i    (burst_mode),
      .wr_en_i    (word_stb),
      .wr_data_i  (word_data),
      .msg_done_i (msg_done),
      .msg_err_i  (msg_err),
      .pop_i      (pop),
      .abandon_i  (abandon),
      .rd_data_o  (head_word),
      .avail_o    (avail)
   );

   rxdma_xfer #(
      .PW         (PW),
      .ADDR_W     (ADDR_W),
      .GRANT_WAIT (GRANT_WAIT)
   ) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .burst_i   (burst_mode),
      .avail_i   (avail),
      .grant_i   (dma_grant),
      .req_o     (dma_req),
      .ack_o     (dma_ack),
      .oe_o      (mem_oe),
      .wr_o      (mem_wr),
      .pop_o     (pop),
      .abandon_o (abandon),
      .hs_fail_o (hs_fail),
      .addr_o    (mem_addr)
   );

   assign sys_data = mem_oe ? head_word : '0;

   // R5: data bus is quiet outside transfer slots
   assert_bus_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe |-> (sys_data == '0));

endmodule

// File: tb/sim_rxdma_buffer.sv
module sim_rxdma_buffer;

   localparam int DW = 16;
   localparam int DP = 8;
   localparam int AWID = 4;
   localparam int GW = 6;

   // {mode, err, words[6], grant delay[4], 4'b0, seed[16]}
   localparam logic [31:0] VEC [8] = '{
      {1'b1, 1'b0, 6'd3, 4'd0, 4'd0, 16'h1000},
      {1'b1, 1'b0, 6'd8, 4'd2, 4'd0, 16'h2000},
      {1'b0, 1'b0, 6'd4, 4'd1, 4'd0, 16'h3000},
      {1'b1, 1'b1, 6'd5, 4'd0, 4'd0, 16'h4000},
      {1'b0, 1'b0, 6'd3, 4'd3, 4'd0, 16'h5000},
      {1'b1, 1'b0, 6'd0, 4'd0, 4'd0, 16'h6000},
      {1'b1, 1'b0, 6'd1, 4'd4, 4'd0, 16'h7000},
      {1'b0, 1'b0, 6'd1, 4'd0, 4'd0, 16'h8000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic burst_mode = 1'b0, word_stb = 1'b0, msg_done = 1'b0, msg_err = 1'b0;
   logic [DW-1:0] word_data = '0;
   logic dma_req, dma_grant, dma_ack, mem_oe, mem_wr, hs_fail;
   logic [AWID-1:0] mem_addr;
   logic [DW-1:0] sys_data;

   always #10 clk = ~clk;

   rxdma_buffer #(.DATA_W(DW), .DEPTH(DP), .ADDR_W(AWID), .GRANT_WAIT(GW)) u0 (
      .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .word_stb(word_stb),
      .word_data(word_data), .msg_done(msg_done), .msg_err(msg_err),
      .dma_req(dma_req), .dma_grant(dma_grant), .dma_ack(dma_ack), .mem_oe(mem_oe),
      .mem_wr(mem_wr), .mem_addr(mem_addr), .sys_data(sys_data), .hs_fail(hs_fail));

   int n_chk = 0, n_fail = 0;
   bit ended = 0;

   // Bus owner model: grants after gdelay cycles of request, if enabled.
   int gdelay = 0, gcnt = 0;
   bit gnt_en = 1;
   initial dma_grant = 1'b0;
   always @(negedge clk) begin
      if (!dma_req) begin
         gcnt <= 0;
         dma_grant <= 1'b0;
      end else begin
         if (gnt_en && gcnt >= gdelay) dma_grant <= 1'b1;
         gcnt <= gcnt + 1;
      end
   end

   // Write log and event counters.
   logic [DW-1:0]   log_data [256];
   logic [AWID-1:0] log_addr [256];
   int wlog = 0, req_rises = 0, fail_cycles = 0;
   logic req_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_wr && wlog < 256) begin
            log_data[wlog] = sys_data;
            log_addr[wlog] = mem_addr;
            wlog++;
         end
         if (dma_req && !req_prev) req_rises++;
         if (hs_fail) fail_cycles++;
      end
      req_prev = dma_req;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic send_msg(input int n, input int seed, input bit err, output bit req_seen);
      req_seen = 0;
      for (int i = 0; i < n; i++) begin
         word_stb = 1'b1;
         word_data = DW'(seed + i);
         @(negedge clk);
         if (dma_req) req_seen = 1;
      end
      word_stb = 1'b0;
      if (err) msg_err = 1'b1; else msg_done = 1'b1;
      @(negedge clk);
      msg_done = 1'b0;
      msg_err = 1'b0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      for (int k = 0; k < 3000 && quiet < 12; k++) begin
         @(negedge clk);
         quiet = dma_req ? 0 : quiet + 1;
      end
   endtask

   int exp_addr = 0;

   task automatic check_writes(input int base, input int n, input int seed, input string tag);
      for (int i = 0; i < n; i++) begin
         chk(log_data[base + i] == DW'(seed + i), {tag, " data R6"},
             int'(log_data[base + i]), seed + i);
         chk(log_addr[base + i] == AWID'(exp_addr + i), {tag, " addr R6"},
             int'(log_addr[base + i]), (exp_addr + i) % (1 << AWID));
      end
      exp_addr += n;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      bit rs;
      int w0, r0;
      // R9: reset state
      repeat (3) @(negedge clk);
      chk({dma_req, dma_ack, mem_oe, mem_wr, hs_fail} == 5'b0, "R9 strobes in reset",
          int'({dma_req, dma_ack, mem_oe, mem_wr, hs_fail}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_addr == '0 && sys_data == '0 && !dma_req, "R9 after reset",
          int'(mem_addr) + int'(sys_data), 0);

      // Vector table
      for (int r = 0; r < 8; r++) begin
         bit md, er;
         int nw, sd, exp_w, exp_r;
         md = VEC[r][31];
         er = VEC[r][30];
         nw = int'(VEC[r][29:24]);
         gdelay = int'(VEC[r][23:20]);
         sd = int'(VEC[r][15:0]);
         burst_mode = md;
         @(negedge clk);
         w0 = wlog;
         r0 = req_rises;
         send_msg(nw, sd, er, rs);
         if (md) chk(!rs, "R2 no request while words arrive", int'(rs), 0);
         wait_idle();
         exp_w = (md && er) ? 0 : nw;
         exp_r = md ? ((nw > 0 && !er) ? 1 : 0) : nw;
         chk(wlog - w0 == exp_w, md ? (er ? "R7 errored block writes" : "R3 block writes")
                                    : "R4 word writes", wlog - w0, exp_w);
         chk(req_rises - r0 == exp_r, md ? "R3 one request per block" : "R4 request per word",
             req_rises - r0, exp_r);
         check_writes(w0, (wlog - w0 < exp_w) ? wlog - w0 : exp_w, sd, "table");
      end
      chk(exp_addr > (1 << AWID), "R6 address wrap exercised", exp_addr, 1 << AWID);

      // R2, R5: cycle-exact block transfer of two words
      burst_mode = 1'b1;
      gdelay = 0;
      @(negedge clk);
      w0 = wlog;
      send_msg(2, 16'hC0DE, 0, rs);
      chk(!dma_req, "R2 request not yet raised", int'(dma_req), 0);
      @(negedge clk);
      chk(dma_req && !dma_ack, "R2 request two cycles after done", int'({dma_req, dma_ack}), 2);
      @(negedge clk);
      chk(dma_ack && mem_oe && !mem_wr, "R5 slot first cycle", int'({dma_ack, mem_oe, mem_wr}), 6);
      @(negedge clk);
      chk(mem_wr && sys_data == 16'hC0DE, "R5 write cycle data", int'(sys_data), 16'hC0DE);
      @(negedge clk);
      chk(dma_ack && !mem_wr, "R5 slot last cycle", int'({dma_ack, mem_wr}), 2);
      @(negedge clk);
      chk(dma_ack && dma_req && !mem_wr, "R3 next slot back-to-back",
          int'({dma_req, dma_ack, mem_wr}), 6);
      @(negedge clk);
      chk(mem_wr && sys_data == 16'hC0DF, "R3 second word data", int'(sys_data), 16'hC0DF);
      @(negedge clk);
      @(negedge clk);
      chk(!dma_req && !dma_ack && sys_data == '0, "R5 bus released", int'({dma_req, dma_ack}), 0);
      wait_idle();
      check_writes(w0, 2, 16'hC0DE, "exact");

      // R7: error on a second message while the first awaits its grant
      gdelay = 4;
      w0 = wlog;
      r0 = req_rises;
      send_msg(2, 16'hA000, 0, rs);
      send_msg(3, 16'hB000, 1, rs);
      wait_idle();
      chk(wlog - w0 == 2, "R7 only committed block written", wlog - w0, 2);
      chk(req_rises - r0 == 1, "R7 no request for errored block", req_rises - r0, 1);
      check_writes(w0, (wlog - w0 < 2) ? wlog - w0 : 2, 16'hA000, "R7");

      // R1: overrun discards the block, then the queue recovers
      gdelay = 0;
      w0 = wlog;
      r0 = req_rises;
      send_msg(DP + 1, 16'hD000, 0, rs);
      wait_idle();
      chk(wlog - w0 == 0, "R1 overrun block dropped", wlog - w0, 0);
      chk(req_rises - r0 == 0, "R1 no request after overrun", req_rises - r0, 0);
      send_msg(2, 16'hD100, 0, rs);
      wait_idle();
      chk(wlog - w0 == 2, "R1 recovery after overrun", wlog - w0, 2);
      check_writes(w0, (wlog - w0 < 2) ? wlog - w0 : 2, 16'hD100, "R1");

      // R8: grant never arrives
      gnt_en = 0;
      burst_mode = 1'b0;
      @(negedge clk);
      w0 = wlog;
      r0 = fail_cycles;
      send_msg(1, 16'hE000, 0, rs);
      wait_idle();
      chk(fail_cycles - r0 == 1, "R8 single fail pulse", fail_cycles - r0, 1);
      chk(wlog - w0 == 0, "R8 no write on timeout", wlog - w0, 0);
      gnt_en = 1;
      burst_mode = 1'b1;
      @(negedge clk);
      send_msg(2, 16'hF000, 0, rs);
      wait_idle();
      chk(wlog - w0 == 2, "R8 abandoned word not replayed", wlog - w0, 2);
      check_writes(w0, (wlog - w0 < 2) ? wlog - w0 : 2, 16'hF000, "R8");

      finish_run();
   end

endmodule